// File: doc/BRIEF.md
# Latency-Aware Issue Interlock

This block decides, at the decode stage of a single-issue in-order pipeline, whether the instruction presented this cycle may issue or must wait. It remembers the destination register, the class and a down-counting age for every recent instruction that writes a register. A new instruction is held, and a bubble goes down the pipe in its place, while any register it reads was written too recently by a producer whose result is not yet usable by that kind of consumer.

The required gap depends on the pair of classes, not only on a register match. A loaded value reaches a store with no gap but needs one bubble before an ALU, FP or branch use. A floating-point add, which spends four execute stages, needs two bubbles before a store and three before any other consumer. An integer ALU result needs one bubble before a branch and none elsewhere. Each branch is followed by one delay slot, and the instruction in that slot goes through the same check as any other. Upstream keeps the held instruction on the inputs until `issue` rises.

Internally a small state machine names each decode cycle: ILK_IDLE (no instruction offered), ILK_FLOW (instruction issues) or ILK_HOLD (instruction stalled). The transitions are: any state to ILK_IDLE when the valid flag is low; any state to ILK_HOLD when a valid instruction meets a blocking producer; any state to ILK_FLOW when a valid instruction meets none. ILK_HOLD is left for ILK_FLOW once the oldest blocking gap has expired.

Top module: `issue_interlock`

## Requirements
- R1: After reset no producer is tracked, so the first instruction after reset issues at once, even if it reads a register written just before reset.
- R2: `issue` is high exactly when `in_valid` is high and no hazard exists; `stall` is high exactly when `in_valid` is high and a hazard exists; with `in_valid` low both are low.
- R3: A store (class code 2) that reads the result of a load (class code 1) issued in the previous cycle issues with zero stall cycles.
- R4: An ALU (code 0), FP add (code 3) or branch (code 4) reading a load result issued in the previous cycle stalls exactly one cycle.
- R5: An instruction of any class other than store that reads an FP add result issued in the previous cycle stalls exactly three cycles.
- R6: A store reading an FP add result issued in the previous cycle stalls exactly two cycles.
- R7: A branch reading an integer ALU result issued in the previous cycle stalls exactly one cycle; an ALU reading an ALU result does not stall.
- R8: Register 0 is never a dependency: a producer writing register 0 is not tracked and a read of register 0 never stalls.
- R9: When several in-flight producers match the sources (on either source port), the stall lasts until the longest remaining gap has expired.
- R10: Stores and branches write no register, so their destination field creates no dependency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered at decode |
| in_cls | input | 3 | Class: 0 ALU, 1 load, 2 store, 3 FP add, 4 branch |
| in_src_a | input | 5 | First source register id |
| in_src_b | input | 5 | Second source register id |
| in_dst | input | 5 | Destination register id |
| stall | output | 1 | Instruction held, bubble inserted |
| issue | output | 1 | Instruction leaves decode this cycle |

## Verification
The two functions that coincide are the ageing of an older producer and the arrival of a newer one matching the same consumer: in one cycle the scoreboard both counts down an FP add record and must weigh a fresh load record on the other source port. The bench provokes this by issuing an FP add, then a load, then an FP add reading both results, and judges by counting stall cycles at the ports, expecting the longer FP gap to win. It also offers a hazardous instruction with the valid flag low in the cycle right after its producer, to confirm that the interlock neither stalls nor issues then.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    typedef enum logic [2:0] {
        OP_ALU    = 3'd0,
        OP_LOAD   = 3'd1,
        OP_STORE  = 3'd2,
        OP_FPADD  = 3'd3,
        OP_BRANCH = 3'd4
    } op_cls_e;

    typedef enum logic [1:0] {
        ILK_IDLE = 2'd0,
        ILK_FLOW = 2'd1,
        ILK_HOLD = 2'd2
    } ilk_state_e;

    // Classes that write a destination register (R10)
    function automatic logic writes_reg(op_cls_e c);
        return (c == OP_ALU) || (c == OP_LOAD) || (c == OP_FPADD);
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
    import ilk_pkg::*;
#(
    parameter int NSLOT   = 3,
    parameter int REG_W   = 5,
    parameter int MAX_GAP = 3,
    localparam int RW     = $clog2(MAX_GAP + 1),
    localparam int IW     = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc,
    input  logic [REG_W-1:0]             alloc_dst,
    input  op_cls_e                      alloc_cls,
    output logic [NSLOT-1:0][RW-1:0]     slot_rem,
    output logic [NSLOT-1:0][REG_W-1:0]  slot_dst,
    output op_cls_e [NSLOT-1:0]          slot_cls
);

    localparam logic [RW-1:0] REM_INIT = RW'(MAX_GAP);
    localparam logic [RW-1:0] REM_ONE  = RW'(1);

    logic          free_found;
    logic [IW-1:0] free_idx;

    // A slot whose counter is at one expires at this edge and may be reused.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (slot_rem[i] <= REM_ONE) begin
                free_found = 1'b1;
                free_idx   = IW'(i);
            end
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_rem[g] <= '0;
                slot_dst[g] <= '0;
                slot_cls[g] <= OP_ALU;
            end else if (alloc && free_found && (free_idx == IW'(g))) begin
                slot_rem[g] <= REM_INIT;
                slot_dst[g] <= alloc_dst;
                slot_cls[g] <= alloc_cls;
            end else if (slot_rem[g] != '0) begin
                slot_rem[g] <= slot_rem[g] - REM_ONE;
            end
        end
    end

    // Enough slots must exist for one producer per cycle over the widest gap.
    AST_SLOT_AVAILABLE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> free_found); // R9

endmodule

// File: rtl/ilk_hazard.sv
module ilk_hazard
    import ilk_pkg::*;
#(
    parameter int NSLOT          = 3,
    parameter int REG_W          = 5,
    parameter int MAX_GAP        = 3,
    parameter int LAT_LOAD_USE   = 1,
    parameter int LAT_LOAD_STORE = 0,
    parameter int LAT_FP_OTHER   = 3,
    parameter int LAT_FP_STORE   = 2,
    parameter int LAT_ALU_BRANCH = 1,
    localparam int RW            = $clog2(MAX_GAP + 1)
) (
    input  logic                         in_valid,
    input  op_cls_e                      in_cls,
    input  logic [REG_W-1:0]             in_src_a,
    input  logic [REG_W-1:0]             in_src_b,
    input  logic [NSLOT-1:0][RW-1:0]     slot_rem,
    input  logic [NSLOT-1:0][REG_W-1:0]  slot_dst,
    input  op_cls_e [NSLOT-1:0]          slot_cls,
    output logic                         hazard
);

    // Bubbles required between a producer and a consumer issued right after it.
    function automatic int gap_of(op_cls_e p, op_cls_e c);
        unique case (p)
            OP_LOAD:  return (c == OP_STORE)  ? LAT_LOAD_STORE : LAT_LOAD_USE;
            OP_FPADD: return (c == OP_STORE)  ? LAT_FP_STORE   : LAT_FP_OTHER;
            OP_ALU:   return (c == OP_BRANCH) ? LAT_ALU_BRANCH : 0;
            default:  return 0;
        endcase
    endfunction

    logic [NSLOT-1:0] blocked;

    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        logic hit_a, hit_b;
        int   need;
        always_comb begin
            hit_a = (in_src_a != '0) && (in_src_a == slot_dst[g]);
            hit_b = (in_src_b != '0) && (in_src_b == slot_dst[g]);
            need  = gap_of(slot_cls[g], in_cls);
            // Elapsed cycles are MAX_GAP - rem; block while fewer than need.
            blocked[g] = (slot_rem[g] != '0) && (hit_a || hit_b) &&
                         (int'(slot_rem[g]) > (MAX_GAP - need));
        end
    end

    assign hazard = in_valid && (|blocked);

endmodule

// File: rtl/ilk_issue_fsm.sv
module ilk_issue_fsm
    import ilk_pkg::*;
#(
    parameter int MAX_GAP = 3,
    localparam int HW     = $clog2(MAX_GAP + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic hazard,
    output logic issue,
    output logic stall
);

    ilk_state_e    state_d, state_q;
    logic [HW-1:0] hold_run;

    always_comb begin
        if (!in_valid)   state_d = ILK_IDLE;
        else if (hazard) state_d = ILK_HOLD;
        else             state_d = ILK_FLOW;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ILK_IDLE;
            hold_run <= '0;
        end else begin
            state_q  <= state_d;
            hold_run <= (state_d == ILK_HOLD) ? hold_run + HW'(1) : '0;
        end
    end

    always_comb begin
        issue = 1'b0;
        stall = 1'b0;
        unique case (state_d)
            ILK_IDLE: ;
            ILK_FLOW: issue = 1'b1;
            ILK_HOLD: stall = 1'b1;
            default:  ;
        endcase
    end

    // No run of bubbles outlasts the widest producer gap.
    AST_HOLD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ILK_HOLD) |-> (hold_run <= HW'(MAX_GAP))); // R5

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
    import ilk_pkg::*;
#(
    parameter int REG_W          = 5,
    parameter int LAT_LOAD_USE   = 1,
    parameter int LAT_LOAD_STORE = 0,
    parameter int LAT_FP_OTHER   = 3,
    parameter int LAT_FP_STORE   = 2,
    parameter int LAT_ALU_BRANCH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_cls,
    input  logic [REG_W-1:0] in_src_a,
    input  logic [REG_W-1:0] in_src_b,
    input  logic [REG_W-1:0] in_dst,
    output logic             stall,
    output logic             issue
);

    localparam int MAX_GAP = max2(max2(max2(LAT_LOAD_USE, LAT_LOAD_STORE),
                                       max2(LAT_FP_OTHER, LAT_FP_STORE)),
                                  max2(LAT_ALU_BRANCH, 1));
    localparam int NSLOT   = MAX_GAP;
    localparam int RW      = $clog2(MAX_GAP + 1);

    op_cls_e                      cls;
    logic                         hazard;
    logic                         alloc;
    logic [NSLOT-1:0][RW-1:0]     slot_rem;
    logic [NSLOT-1:0][REG_W-1:0]  slot_dst;
    op_cls_e [NSLOT-1:0]          slot_cls;

    assign cls   = op_cls_e'(in_cls);
    assign alloc = issue && writes_reg(cls) && (in_dst != '0);

    ilk_scoreboard #(
        .NSLOT   (NSLOT),
        .REG_W   (REG_W),
        .MAX_GAP (MAX_GAP)
    ) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (alloc),
        .alloc_dst (in_dst),
        .alloc_cls (cls),
        .slot_rem  (slot_rem),
        .slot_dst  (slot_dst),
        .slot_cls  (slot_cls)
    );

    ilk_hazard #(
        .NSLOT          (NSLOT),
        .REG_W          (REG_W),
        .MAX_GAP        (MAX_GAP),
        .LAT_LOAD_USE   (LAT_LOAD_USE),
        .LAT_LOAD_STORE (LAT_LOAD_STORE),
        .LAT_FP_OTHER   (LAT_FP_OTHER),
        .LAT_FP_STORE   (LAT_FP_STORE),
        .LAT_ALU_BRANCH (LAT_ALU_BRANCH)
    ) u_hz (
        .in_valid (in_valid),
        .in_cls   (cls),
        .in_src_a (in_src_a),
        .in_src_b (in_src_b),
        .slot_rem (slot_rem),
        .slot_dst (slot_dst),
        .slot_cls (slot_cls),
        .hazard   (hazard)
    );

    ilk_issue_fsm #(
        .MAX_GAP (MAX_GAP)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .hazard   (hazard),
        .issue    (issue),
        .stall    (stall)
    );

    AST_CLEAN_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !stall); // R1

    AST_ZERO_NEVER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_src_a == '0 && in_src_b == '0) |-> !stall); // R8

    AST_FP_TO_FP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue) && $past(in_cls) == OP_FPADD && $past(in_dst) != '0 &&
         in_valid && cls == OP_FPADD && in_src_a == $past(in_dst)) |-> stall); // R5

    AST_FP_TO_STORE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(issue) && $past(in_cls) == OP_FPADD && $past(in_dst) != '0 &&
         in_valid && cls == OP_STORE && in_src_a == $past(in_dst)) |-> stall); // R6

    AST_QUIET_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!issue && !stall)); // R2

endmodule

// File: tb/sim_issue_interlock.sv
`timescale 1ns/100ps
module sim_issue_interlock;

    localparam logic [2:0] C_ALU = 3'd0, C_LD = 3'd1, C_ST = 3'd2, C_FP = 3'd3, C_BR = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_cls = '0;
    logic [4:0] in_src_a = '0, in_src_b = '0, in_dst = '0;
    logic       stall, issue;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    issue_interlock u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
        .stall(stall), .issue(issue)
    );

    // {producer, consumer, dependent, expected stalls}
    localparam int NV = 12;
    localparam logic [9:0] VEC [NV] = '{
        {C_LD,  C_ST,  1'b1, 3'd0},  // R3
        {C_LD,  C_ALU, 1'b1, 3'd1},  // R4
        {C_LD,  C_FP,  1'b1, 3'd1},  // R4
        {C_LD,  C_BR,  1'b1, 3'd1},  // R4
        {C_FP,  C_FP,  1'b1, 3'd3},  // R5
        {C_FP,  C_ALU, 1'b1, 3'd3},  // R5
        {C_FP,  C_ST,  1'b1, 3'd2},  // R6
        {C_ALU, C_BR,  1'b1, 3'd1},  // R7
        {C_ALU, C_ALU, 1'b1, 3'd0},  // R7
        {C_ALU, C_ST,  1'b1, 3'd0},  // R7
        {C_FP,  C_FP,  1'b0, 3'd0},  // R2 independent registers
        {C_LD,  C_ALU, 1'b0, 3'd0}   // R2 independent registers
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] c, input logic [4:0] a,
                         input logic [4:0] b, input logic [4:0] d);
        in_valid = v; in_cls = c; in_src_a = a; in_src_b = b; in_dst = d;
    endtask

    // Called just after a negedge with the consumer driven; returns bubbles seen.
    task automatic measure(output int n);
        n = 0;
        #1;
        while (stall && n < 10) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            drive(1'b0, C_ALU, 5'd0, 5'd0, 5'd0);
        end
    endtask

    // Issue one instruction at the next negedge and let it pass the edge.
    task automatic issue_one(input logic [2:0] c, input logic [4:0] d, input string req);
        @(negedge clk);
        drive(1'b1, c, 5'd1, 5'd2, d);
        #1;
        check(issue === 1'b1, req, int'(issue), 1);
    endtask

    initial begin
        #(5.0 * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(stall === 1'b0 && issue === 1'b0, "R1 idle after reset", int'(stall), 0);

        // Table of producer/consumer pairs
        for (int v = 0; v < NV; v++) begin
            logic [2:0] pc, cc;
            logic       dep;
            int         exp;
            pc  = VEC[v][9:7];
            cc  = VEC[v][6:4];
            dep = VEC[v][3];
            exp = int'(VEC[v][2:0]);
            idle(4);
            issue_one(pc, 5'd9, "R2 producer issue");
            @(negedge clk);
            drive(1'b1, cc, dep ? 5'd9 : 5'd4, 5'd5, 5'd10);
            measure(n);
            check(n == exp, $sformatf("R3-R7 pair %0d stall count", v), n, exp);
            check(issue === 1'b1, "R2 issue after wait", int'(issue), 1);
        end

        // R1: a producer before reset leaves no trace
        idle(4);
        issue_one(C_FP, 5'd3, "R1 producer");
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, C_ALU, 5'd0, 5'd0, 5'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, C_FP, 5'd3, 5'd0, 5'd4);
        measure(n);
        check(n == 0, "R1 no stall after reset", n, 0);

        // R2: hazardous instruction with valid low neither stalls nor issues
        idle(4);
        issue_one(C_FP, 5'd3, "R2 producer");
        @(negedge clk);
        drive(1'b0, C_FP, 5'd3, 5'd0, 5'd4);
        #1;
        check(stall === 1'b0 && issue === 1'b0, "R2 valid low", int'({stall, issue}), 0);
        @(negedge clk);
        in_valid = 1'b1;
        measure(n);
        check(n == 2, "R2 remaining wait after gap", n, 2);

        // R8: register 0 as destination and as source
        idle(4);
        issue_one(C_LD, 5'd0, "R8 producer");
        @(negedge clk);
        drive(1'b1, C_ALU, 5'd0, 5'd0, 5'd6);
        measure(n);
        check(n == 0, "R8 load to r0", n, 0);
        idle(4);
        issue_one(C_FP, 5'd0, "R8 producer");
        @(negedge clk);
        drive(1'b1, C_FP, 5'd0, 5'd0, 5'd6);
        measure(n);
        check(n == 0, "R8 fp to r0", n, 0);

        // R10: store and branch destination fields are ignored
        idle(4);
        issue_one(C_ST, 5'd7, "R10 store");
        @(negedge clk);
        drive(1'b1, C_FP, 5'd7, 5'd0, 5'd8);
        measure(n);
        check(n == 0, "R10 store dst ignored", n, 0);
        idle(4);
        issue_one(C_BR, 5'd7, "R10 branch");
        @(negedge clk);
        drive(1'b1, C_ALU, 5'd7, 5'd0, 5'd8);
        measure(n);
        check(n == 0, "R10 branch dst ignored", n, 0);

        // R9: FP add then load, consumer reads both (load on port b)
        idle(4);
        issue_one(C_FP, 5'd5, "R9 fp producer");
        issue_one(C_LD, 5'd6, "R9 load producer");
        @(negedge clk);
        drive(1'b1, C_FP, 5'd5, 5'd6, 5'd11);
        measure(n);
        check(n == 2, "R9 longest gap wins", n, 2);

        // R9: load on port b alone while an expired producer sits in a slot
        idle(4);
        issue_one(C_ALU, 5'd12, "R9 alu producer");
        issue_one(C_LD, 5'd13, "R9 load producer");
        @(negedge clk);
        drive(1'b1, C_BR, 5'd0, 5'd13, 5'd0);
        measure(n);
        check(n == 1, "R9 port b load to branch", n, 1);

        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule